// File: doc/BRIEF.md
# Bus Cycle Break Comparator

This block watches every bus cycle issued by the processor or by the DMA engine and raises a break request when the cycle matches a programmed condition. Each cycle arrives as an address, a data word, an access size (byte, word or longword), a flag telling an instruction fetch from a data access, a flag naming the bus master, and a read/write flag. The condition combines an address, an optional size, an optional masked data value, the masters allowed and the directions allowed.

The address is compared at the granularity of the access. A longword cycle matches any break address inside the same aligned four bytes. A word cycle matches inside the same aligned two bytes. A byte cycle must match exactly. So with no size condition, a break address of 0x00001003 catches a longword at 0x00001000, a word at 0x00001002 and a byte at 0x00001003. The data condition works on lanes. Longword compares all 32 bits. Word compares the low half. Byte accepts a match on either of the two low byte lanes, because software writes the same byte into both. Fetch cycles skip the data condition, and DMA cycles never match when the size condition is longword.

The condition registers are loaded through four simple write ports. The request is a registered pulse that lasts one clock per matching cycle.

Top module: `bus_break_cmp`

## Requirements
- R1: Reset clears the address, data, mask and control registers and drives `brk_req` low. No request is raised while control bit 0 (arm) is 0. Each register keeps its value until its write enable is pulsed.
- R2: The bus size encoding is 1 = byte, 2 = word and 3 = longword. For a longword cycle, break address bits 31..2 are compared with bus address bits 31..2.
- R3: For a word cycle, address bits 31..1 are compared.
- R4: For a byte cycle, all address bits 31..0 are compared.
- R5: Control bits 3..2 select the size condition, with 0 = any size and 1/2/3 as in R2. A nonzero setting matches only cycles whose bus size is equal to it.
- R6: Control bit 1 enables the data condition. A mask bit of 1 makes that data bit a don't-care, and a mask bit of 0 requires equality. With longword size all 32 bits are compared. When the data condition is enabled, a request needs both the address and the data conditions to hold, and a size setting of 0 never matches.
- R7: With word or byte size, bits 31..16 of the bus data, break data and mask have no effect.
- R8: With byte size, the data condition holds if bits 7..0 match or if bits 15..8 match, each lane under its own mask byte.
- R9: On an instruction fetch cycle the data condition is ignored, and only the address, size, master and direction conditions decide.
- R10: A DMA cycle never matches while the size setting is longword.
- R11: Control bits 5..4 allow masters (bit 4 allows the CPU, bit 5 allows the DMA). Control bits 7..6 allow directions (bit 6 allows reads, bit 7 allows writes). A cycle from a master or in a direction that is not allowed never matches.
- R12: `brk_req` is high for exactly the one clock that follows a matching cycle with `bus_valid` high. It is low after any cycle with `bus_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_addr_we | input | 1 | Load the break address |
| cond_addr_wdata | input | 32 | Break address value |
| cond_data_we | input | 1 | Load the break data |
| cond_data_wdata | input | 32 | Break data value |
| cond_mask_we | input | 1 | Load the data mask |
| cond_mask_wdata | input | 32 | Data mask value (1 = don't care) |
| cond_ctrl_we | input | 1 | Load the control word |
| cond_ctrl_wdata | input | 8 | Control word: arm, data enable, size, master allow, direction allow |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| bus_size | input | 2 | Access size: 1 byte, 2 word, 3 longword |
| bus_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_dma | input | 1 | 1 when the DMA engine owns the cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| brk_req | output | 1 | One-clock break request |

## Verification
The assertions assume that `bus_size` is never 0 while `bus_valid` is high. They also assume that the condition registers are written only while no bus cycle is being presented, so a request always reflects one stable configuration. The stimulus keeps to both rules: it drives sizes 1 to 3 only, and every configuration write happens with `bus_valid` low. Within those limits, the bench sweeps every size setting, data enable, master mask and direction mask against every access size, address offset, master, direction and cycle type. It rotates data patterns that match on the full word, on one low lane only, or on neither.

// File: rtl/brk_pkg.sv
package brk_pkg;

    // Access size / size condition encoding
    typedef enum logic [1:0] {
        SZ_ANY  = 2'd0,
        SZ_BYTE = 2'd1,
        SZ_WORD = 2'd2,
        SZ_LONG = 2'd3
    } brk_size_e;

    // Control word, MSB first: rw_allow[7:6] mst_allow[5:4] size_sel[3:2] data_en[1] arm[0]
    typedef struct packed {
        logic [1:0] rw_allow;
        logic [1:0] mst_allow;
        brk_size_e  size_sel;
        logic       data_en;
        logic       arm;
    } brk_ctrl_t;

    localparam int CTRL_W = $bits(brk_ctrl_t);

endpackage

// File: rtl/brk_cfg_regs.sv
module brk_cfg_regs
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              mask_we,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [ADDR_W-1:0] brk_addr,
    output logic [DATA_W-1:0] brk_data,
    output logic [DATA_W-1:0] brk_mask,
    output brk_ctrl_t         brk_ctrl
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
        brk_ctrl_t         ctrl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (addr_we) cfg_d.addr = addr_wdata;
        if (data_we) cfg_d.data = data_wdata;
        if (mask_we) cfg_d.mask = mask_wdata;
        if (ctrl_we) cfg_d.ctrl = brk_ctrl_t'(ctrl_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign brk_addr = cfg_q.addr;
    assign brk_data = cfg_q.data;
    assign brk_mask = cfg_q.mask;
    assign brk_ctrl = cfg_q.ctrl;

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(brk_ctrl));

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_we |=> $stable(brk_addr));

endmodule

// File: rtl/brk_addr_cmp.sv
module brk_addr_cmp
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] brk_addr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  brk_size_e         bus_size,
    output logic              hit
);

    logic [ADDR_W-1:0] care;

    // Low address bits below the access granularity are excluded
    always_comb begin
        care = '1;
        case (bus_size)
            SZ_LONG: care[1:0] = 2'b00;
            SZ_WORD: care[0]   = 1'b0;
            default: care      = '1;
        endcase
        hit = (((brk_addr ^ bus_addr) & care) == '0);
    end

    always_comb begin
        if (!$isunknown({bus_size, hit, brk_addr, bus_addr})) begin
            // R4
            byte_exact_chk: assert (!(hit && bus_size == SZ_BYTE) || brk_addr == bus_addr);
            // R2
            long_upper_chk: assert (!(hit && bus_size == SZ_LONG)
                                    || brk_addr[ADDR_W-1:2] == bus_addr[ADDR_W-1:2]);
        end
    end

endmodule

// File: rtl/brk_data_cmp.sv
module brk_data_cmp
    import brk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] ref_data,
    input  logic [DATA_W-1:0] ref_mask,
    input  logic [DATA_W-1:0] bus_data,
    input  brk_size_e         size_sel,
    output logic              hit
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0] lane_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_ok[g] =
            (((ref_data[g*8 +: 8] ^ bus_data[g*8 +: 8]) & ~ref_mask[g*8 +: 8]) == 8'h00);
    end

    always_comb begin
        case (size_sel)
            SZ_BYTE: hit = lane_ok[0] | lane_ok[1];
            SZ_WORD: hit = &lane_ok[1:0];
            SZ_LONG: hit = &lane_ok;
            default: hit = 1'b0;
        endcase
    end

    always_comb begin
        if (!$isunknown({size_sel, hit})) begin
            // R6
            any_size_no_hit_chk: assert (size_sel != SZ_ANY || !hit);
        end
    end

endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
    import brk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cond_addr_we,
    input  logic [ADDR_W-1:0] cond_addr_wdata,
    input  logic              cond_data_we,
    input  logic [DATA_W-1:0] cond_data_wdata,
    input  logic              cond_mask_we,
    input  logic [DATA_W-1:0] cond_mask_wdata,
    input  logic              cond_ctrl_we,
    input  logic [CTRL_W-1:0] cond_ctrl_wdata,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        bus_size,
    input  logic              bus_fetch,
    input  logic              bus_dma,
    input  logic              bus_write,
    output logic              brk_req
);

    typedef struct packed {
        logic req;
    } req_state_t;

    logic [ADDR_W-1:0] brk_addr;
    logic [DATA_W-1:0] brk_data;
    logic [DATA_W-1:0] brk_mask;
    brk_ctrl_t         ctrl;
    brk_size_e         bsize;
    logic              addr_hit;
    logic              data_hit;
    logic              size_ok;
    logic              mst_ok;
    logic              dir_ok;
    logic              dma_ok;
    logic              data_ok;
    req_state_t        st_d, st_q;

    assign bsize = brk_size_e'(bus_size);

    brk_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_we    (cond_addr_we),
        .addr_wdata (cond_addr_wdata),
        .data_we    (cond_data_we),
        .data_wdata (cond_data_wdata),
        .mask_we    (cond_mask_we),
        .mask_wdata (cond_mask_wdata),
        .ctrl_we    (cond_ctrl_we),
        .ctrl_wdata (cond_ctrl_wdata),
        .brk_addr   (brk_addr),
        .brk_data   (brk_data),
        .brk_mask   (brk_mask),
        .brk_ctrl   (ctrl)
    );

    brk_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
        .brk_addr (brk_addr),
        .bus_addr (bus_addr),
        .bus_size (bsize),
        .hit      (addr_hit)
    );

    brk_data_cmp #(.DATA_W(DATA_W)) u_data (
        .ref_data (brk_data),
        .ref_mask (brk_mask),
        .bus_data (bus_data),
        .size_sel (ctrl.size_sel),
        .hit      (data_hit)
    );

    always_comb begin
        size_ok = (ctrl.size_sel == SZ_ANY) || (ctrl.size_sel == bsize);
        mst_ok  = bus_dma   ? ctrl.mst_allow[1] : ctrl.mst_allow[0];
        dir_ok  = bus_write ? ctrl.rw_allow[1]  : ctrl.rw_allow[0];
        dma_ok  = !(bus_dma && ctrl.size_sel == SZ_LONG);
        data_ok = !ctrl.data_en || bus_fetch || data_hit;
        st_d.req = bus_valid && ctrl.arm && addr_hit && size_ok
                   && mst_ok && dir_ok && dma_ok && data_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign brk_req = st_q.req;

    // R12
    req_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> $past(bus_valid));

    // R10
    dma_long_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_dma && ctrl.size_sel == SZ_LONG) |=> !brk_req);

    // R11
    master_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_dma && !ctrl.mst_allow[1]) |=> !brk_req);

    // R1
    disarmed_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.arm |=> !brk_req);

endmodule

// File: tb/tb_bus_break_cmp.sv
module tb_bus_break_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cond_addr_we = 1'b0;
    logic [31:0] cond_addr_wdata = '0;
    logic        cond_data_we = 1'b0;
    logic [31:0] cond_data_wdata = '0;
    logic        cond_mask_we = 1'b0;
    logic [31:0] cond_mask_wdata = '0;
    logic        cond_ctrl_we = 1'b0;
    logic [7:0]  cond_ctrl_wdata = '0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic [1:0]  bus_size = 2'd1;
    logic        bus_fetch = 1'b0;
    logic        bus_dma = 1'b0;
    logic        bus_write = 1'b0;
    logic        brk_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] c_addr, c_data, c_mask;
    logic [7:0]  c_ctrl;

    always #5 clk = ~clk;

    bus_break_cmp dut (.*);

    function automatic logic [31:0] pat(input int k);
        case (k % 6)
            0: return 32'hDEAD5A5A;   // full match
            1: return 32'h11115A5A;   // upper half differs
            2: return 32'hDEAD3C5A;   // low lane only
            3: return 32'hDEAD5A3C;   // lane 1 only
            4: return 32'hDEAD5353;   // differs only in masked nibble
            default: return 32'hDEADA5A5;
        endcase
    endfunction

    function automatic bit expect_hit(input logic [31:0] a, input logic [31:0] d,
                                      input int bs, input bit f, input bit dm, input bit w);
        int  ss;
        bit  a_ok, d_ok;
        logic [31:0] x;
        ss = int'(c_ctrl[3:2]);
        x  = (a ^ c_addr);
        if (bs == 3)      a_ok = (x[31:2] == 30'd0);
        else if (bs == 2) a_ok = (x[31:1] == 31'd0);
        else              a_ok = (x == 32'd0);
        x = (d ^ c_data) & ~c_mask;
        if (!c_ctrl[1] || f) d_ok = 1'b1;
        else if (ss == 3)    d_ok = (x == 32'd0);
        else if (ss == 2)    d_ok = (x[15:0] == 16'd0);
        else if (ss == 1)    d_ok = (x[7:0] == 8'd0) || (x[15:8] == 8'd0);
        else                 d_ok = 1'b0;
        return c_ctrl[0] && a_ok && (ss == 0 || ss == bs)
               && (dm ? c_ctrl[5] : c_ctrl[4]) && (w ? c_ctrl[7] : c_ctrl[6])
               && !(dm && ss == 3) && d_ok;
    endfunction

    function automatic string tag_of(input int bs, input bit f, input bit dm, input bit w);
        int ss;
        ss = int'(c_ctrl[3:2]);
        if (!c_ctrl[0])                                  return "R1";
        if (dm && ss == 3)                               return "R10";
        if (!(dm ? c_ctrl[5] : c_ctrl[4]) || !(w ? c_ctrl[7] : c_ctrl[6])) return "R11";
        if (ss != 0 && ss != bs)                         return "R5";
        if (c_ctrl[1] && f)                              return "R9";
        if (c_ctrl[1] && ss == 1)                        return "R8";
        if (c_ctrl[1] && ss == 2)                        return "R7";
        if (c_ctrl[1])                                   return "R6";
        if (bs == 3)                                     return "R2";
        if (bs == 2)                                     return "R3";
        return "R4";
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: brk_req=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic load_cfg(input logic [31:0] a, input logic [31:0] d,
                            input logic [31:0] m, input logic [7:0] c);
        @(negedge clk);
        bus_valid = 1'b0;
        cond_addr_we = 1'b1; cond_addr_wdata = a;
        cond_data_we = 1'b1; cond_data_wdata = d;
        cond_mask_we = 1'b1; cond_mask_wdata = m;
        cond_ctrl_we = 1'b1; cond_ctrl_wdata = c;
        @(posedge clk); #1;
        cond_addr_we = 1'b0; cond_data_we = 1'b0;
        cond_mask_we = 1'b0; cond_ctrl_we = 1'b0;
        c_addr = a; c_data = d; c_mask = m; c_ctrl = c;
    endtask

    task automatic load_ctrl(input logic [7:0] c);
        @(negedge clk);
        bus_valid = 1'b0;
        cond_ctrl_we = 1'b1; cond_ctrl_wdata = c;
        @(posedge clk); #1;
        cond_ctrl_we = 1'b0;
        c_ctrl = c;
    endtask

    // Present one cycle; the request appears after the next rising edge
    task automatic cyc(input bit v, input logic [31:0] a, input logic [31:0] d,
                       input int bs, input bit f, input bit dm, input bit w,
                       input string req, input bit exp);
        @(negedge clk);
        bus_valid = v; bus_addr = a; bus_data = d; bus_size = 2'(bs);
        bus_fetch = f; bus_dma = dm; bus_write = w;
        @(posedge clk); #1;
        check(req, brk_req, exp);
    endtask

    initial begin
        c_addr = '0; c_data = '0; c_mask = '0; c_ctrl = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", brk_req, 1'b0);
        rst_n = 1'b1;

        // R1: no arm after reset, a cycle that would match is ignored
        cyc(1, 32'h0, 32'h0, 1, 0, 0, 0, "R1 disarmed after reset", 1'b0);

        // R2 example: longword at the aligned base, not at the next word
        load_cfg(32'h00001003, 32'hDEAD5A5A, 32'h00000F0F, 8'hF1);
        cyc(1, 32'h00001000, 32'h0, 3, 0, 0, 0, "R2 long at 0x1000", 1'b1);
        cyc(1, 32'h00001004, 32'h0, 3, 0, 0, 0, "R2 long at 0x1004", 1'b0);
        cyc(1, 32'h00001002, 32'h0, 2, 0, 0, 0, "R3 word at 0x1002", 1'b1);
        cyc(1, 32'h00001003, 32'h0, 1, 0, 0, 0, "R4 byte at 0x1003", 1'b1);
        cyc(1, 32'h80001003, 32'h0, 1, 0, 0, 0, "R4 upper bit differs", 1'b0);

        // R12: one pulse per cycle, none without valid
        cyc(0, 32'h00001003, 32'h0, 1, 0, 0, 0, "R12 valid low", 1'b0);
        cyc(1, 32'h00001003, 32'h0, 1, 0, 0, 0, "R12 first pulse", 1'b1);
        cyc(1, 32'h00001003, 32'h0, 1, 0, 0, 0, "R12 second pulse", 1'b1);
        cyc(0, 32'h00001003, 32'h0, 1, 0, 0, 0, "R12 pulse ends", 1'b0);

        // Exhaustive sweep over control settings and cycle attributes
        for (int ss = 0; ss < 4; ss++)
            for (int de = 0; de < 2; de++)
                for (int ms = 0; ms < 4; ms++)
                    for (int rs = 0; rs < 4; rs++) begin
                        load_ctrl({2'(rs), 2'(ms), 2'(ss), 1'(de), 1'b1});
                        for (int bs = 1; bs < 4; bs++)
                            for (int lo = 0; lo < 8; lo++)
                                for (int f = 0; f < 2; f++)
                                    for (int dm = 0; dm < 2; dm++)
                                        for (int w = 0; w < 2; w++) begin
                                            logic [31:0] a, d;
                                            a = 32'h00001000 + 32'(lo);
                                            d = pat(lo + bs + 2 * f + w + ms);
                                            cyc(1, a, d, bs, 1'(f), 1'(dm), 1'(w),
                                                tag_of(bs, 1'(f), 1'(dm), 1'(w)),
                                                expect_hit(a, d, bs, 1'(f), 1'(dm), 1'(w)));
                                        end
                    end

        // R1: disarming stops requests
        load_ctrl(8'hF0);
        cyc(1, 32'h00001003, 32'h0, 1, 0, 0, 0, "R1 disarmed", 1'b0);

        @(negedge clk);
        bus_valid = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule